// File: doc/BRIEF.md
# Best-Time Stopwatch Controller

This block is a stopwatch that remembers the shortest run it has timed. A control state machine drives a small datapath: a four-digit BCD elapsed-time counter, a four-digit best-time record register with a two-way load source (an all-nines preset or the elapsed time), and a digit-wise BCD magnitude comparator. A sixteen-bit display bus shows either the elapsed time or the stored record.

The user arms the watch, clears the timer with `go`, starts counting with a second `go` and freezes the count with `halt`. From the frozen state, `keep` asks the block to compare the run with the record. The record is overwritten only when the new time is strictly smaller, and the display then switches to the record. A `go` in the frozen state starts a fresh run and discards the time. The five control strobes are brought out as ports so the sequencing can be observed.

Top module: `best_time_watch`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, the block is in the arm state: the elapsed time is 0000, the record is BCD 9999 (16'h9999), `load_rec` is 1, the other four strobes are 0 and `disp` is 16'h0000.
- R2: In the arm state, `load_rec` is 1 and the record is loaded with 16'h9999 at each clock. `go` moves to the clear state and any other input keeps the arm state.
- R3: In the clear state, `clr_time` is 1 and the elapsed time becomes 0000 at the next clock. `go` moves to the run state, and `halt` and `keep` have no effect.
- R4: In the run state, `count_en` is 1 and the elapsed time increases by one in BCD at every clock, including the clock on which `halt` is sampled. A digit at 9 returns to 0 and carries into the next digit. `halt` moves to the hold state, and `go` and `keep` have no effect.
- R5: An elapsed time of 9999 in the run state becomes 0000 at the next clock.
- R6: In the hold state all strobes are 0 and the elapsed time does not change. `keep` moves to the compare state and takes priority over `go`. `go` alone moves to the clear state, and with neither input the hold state remains.
- R7: The compare state lasts one cycle with all strobes 0. It moves to the store state when the elapsed time, read as BCD digits with the most significant first, is strictly less than the record, and to the show state otherwise (an equal time does not store).
- R8: The store state lasts one cycle with `load_rec` and `take_time` both 1. The record takes the elapsed time at the next clock and the next state is the show state.
- R9: In the show state, `show_rec` is 1 and `disp` carries the record. `go` moves to the clear state. The record is kept across later runs and is preset again only in the arm state.
- R10: `disp` carries the elapsed time whenever `show_rec` is 0. At most one of `clr_time`, `count_en`, `take_time` and `show_rec` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start / new-run request |
| halt | input | 1 | Stop counting |
| keep | input | 1 | Compare the run with the record and keep it if better |
| disp | output | 16 | Display bus: elapsed time or record, four BCD digits |
| load_rec | output | 1 | Record register load strobe |
| clr_time | output | 1 | Elapsed-time clear strobe |
| count_en | output | 1 | Elapsed-time count enable |
| take_time | output | 1 | Record load source selects the elapsed time |
| show_rec | output | 1 | Display selects the record |

## Verification
A reference model steps alongside the design under random `go`, `halt` and `keep` patterns. These patterns produce runs of many lengths, so some runs beat the record and some do not, and the model shows whether the comparator and the store path pick the right branch. Inputs raised together in the hold state show whether `keep` takes priority over `go`. Directed cases add a run that lasts exactly as long as the record, which must not store, and a run of more than ten thousand counts, which checks the carry across all four digits and the wrap from 9999 to 0000.

// File: rtl/best_time_watch.sv
module best_time_watch #(
  parameter int DIGITS = 4,
  localparam int W = 4 * DIGITS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic         halt,
  input  logic         keep,
  output logic [W-1:0] disp,
  output logic         load_rec,
  output logic         clr_time,
  output logic         count_en,
  output logic         take_time,
  output logic         show_rec
);

  localparam logic [W-1:0] ALL_NINE = {DIGITS{4'h9}};

  typedef enum logic [2:0] {
    ST_ARM, ST_CLEAR, ST_RUN, ST_HOLD, ST_CMP, ST_STORE, ST_SHOW
  } state_t;

  state_t state, state_nx;
  logic [W-1:0] elapsed, record, elapsed_inc;
  logic         less;
  logic [DIGITS:0] carry;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) state <= ST_ARM;
    else        state <= state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_ARM:   if (go) state_nx = ST_CLEAR;
      ST_CLEAR: if (go) state_nx = ST_RUN;
      ST_RUN:   if (halt) state_nx = ST_HOLD;
      ST_HOLD:  if (keep) state_nx = ST_CMP;
                else if (go) state_nx = ST_CLEAR;
      ST_CMP:   state_nx = less ? ST_STORE : ST_SHOW;
      ST_STORE: state_nx = ST_SHOW;
      ST_SHOW:  if (go) state_nx = ST_CLEAR;
      default:  state_nx = ST_ARM;
    endcase
  end

  assign load_rec  = (state == ST_ARM) || (state == ST_STORE);
  assign take_time = (state == ST_STORE);
  assign clr_time  = (state == ST_CLEAR);
  assign count_en  = (state == ST_RUN);
  assign show_rec  = (state == ST_SHOW);

  assign carry[0] = 1'b1;
  for (genvar i = 0; i < DIGITS; i++) begin : g_digit
    logic [3:0] d;
    logic       nine;
    assign d    = elapsed[4*i +: 4];
    assign nine = (d == 4'd9);
    assign carry[i+1] = carry[i] & nine;
    assign elapsed_inc[4*i +: 4] = !carry[i] ? d : (nine ? 4'd0 : d + 4'd1);
  end

  always_comb begin
    logic decided;
    decided = 1'b0;
    less    = 1'b0;
    for (int i = DIGITS - 1; i >= 0; i--) begin
      if (!decided && elapsed[4*i +: 4] != record[4*i +: 4]) begin
        decided = 1'b1;
        less    = elapsed[4*i +: 4] < record[4*i +: 4];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        elapsed <= '0;
    else if (clr_time) elapsed <= '0;
    else if (count_en) elapsed <= elapsed_inc;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        record <= ALL_NINE;
    else if (load_rec) record <= take_time ? elapsed : ALL_NINE;

  assign disp = show_rec ? record : elapsed;

endmodule

module best_time_watch_chk #(
  parameter int DIGITS = 4,
  localparam int W = 4 * DIGITS
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] elapsed,
  input logic [W-1:0] record,
  input logic         load_rec,
  input logic         clr_time,
  input logic         count_en,
  input logic         take_time,
  input logic         show_rec
);
  localparam logic [W-1:0] ALL_NINE = {DIGITS{4'h9}};

  a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr_time |=> elapsed == '0);
  a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    count_en && elapsed == ALL_NINE |=> elapsed == '0);
  a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !count_en && !clr_time |=> $stable(elapsed));
  a_r2_preset: assert property (@(posedge clk) disable iff (!rst_n)
    load_rec && !take_time |=> record == ALL_NINE);
  a_r7_only_smaller: assert property (@(posedge clk) disable iff (!rst_n)
    take_time |-> elapsed < record);
  a_r8_store: assert property (@(posedge clk) disable iff (!rst_n)
    take_time |=> record == $past(elapsed) && show_rec);
  a_r8_load_pair: assert property (@(posedge clk) disable iff (!rst_n)
    take_time |-> load_rec);
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({clr_time, count_en, take_time, show_rec}));
endmodule

bind best_time_watch best_time_watch_chk #(.DIGITS(DIGITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .elapsed(elapsed), .record(record),
  .load_rec(load_rec), .clr_time(clr_time), .count_en(count_en),
  .take_time(take_time), .show_rec(show_rec)
);

// File: tb/sim_best_time_watch.sv
module sim_best_time_watch;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 1'b0, halt = 1'b0, keep = 1'b0;
  logic [15:0] disp;
  logic load_rec, clr_time, count_en, take_time, show_rec;

  int total = 0, bad = 0;
  int ms = 0, mt = 0, mr = 9999;
  bit done = 1'b0;

  always #10 clk = ~clk;

  best_time_watch u0 (
    .clk(clk), .rst_n(rst_n), .go(go), .halt(halt), .keep(keep),
    .disp(disp), .load_rec(load_rec), .clr_time(clr_time),
    .count_en(count_en), .take_time(take_time), .show_rec(show_rec)
  );

  function automatic logic [15:0] to_bcd(int v);
    return {4'(v / 1000), 4'((v / 100) % 10), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  function automatic logic [20:0] expect_out();
    logic [15:0] d;
    d = (ms == 6) ? to_bcd(mr) : to_bcd(mt);
    return {d, ms == 0 || ms == 5, ms == 1, ms == 2, ms == 5, ms == 6};
  endfunction

  function automatic string state_tag();
    case (ms)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R6";
      4: return "R7";
      5: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string tag);
    logic [20:0] act, exp;
    act = {disp, load_rec, clr_time, count_en, take_time, show_rec};
    exp = expect_out();
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s R10 st=%0d act=%h exp=%h", tag, ms, act, exp);
    end
  endtask

  task automatic model_step(bit g, bit h, bit k);
    case (ms)
      0: begin mr = 9999; if (g) ms = 1; end
      1: begin mt = 0; if (g) ms = 2; end
      2: begin mt = (mt + 1) % 10000; if (h) ms = 3; end
      3: if (k) ms = 4; else if (g) ms = 1;
      4: ms = (mt < mr) ? 5 : 6;
      5: begin mr = mt; ms = 6; end
      default: if (g) ms = 1;
    endcase
  endtask

  task automatic cyc(bit g, bit h, bit k, string tag = "");
    go = g; halt = h; keep = k;
    @(posedge clk);
    model_step(g, h, k);
    @(negedge clk);
    check(tag == "" ? state_tag() : tag);
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk); @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    check("R1");
    cyc(0, 1, 1);                     // R2: halt/keep ignored in arm
    cyc(1, 0, 0);                     // R2 -> clear
    cyc(0, 1, 1);                     // R3 ignored inputs
    cyc(1, 0, 0);                     // R3 -> run
    for (int i = 0; i < 4; i++) cyc(1, 0, 1);   // R4 go/keep ignored
    cyc(0, 1, 0);                     // R4 halt
    cyc(0, 0, 0);                     // R6 idle hold
    cyc(1, 0, 1);                     // R6 keep wins
    cyc(0, 0, 0, "R7");
    cyc(0, 0, 0, "R8");
    cyc(0, 0, 0, "R9");
    // equal-time run: R7 must not store
    cyc(1, 0, 0); cyc(1, 0, 0);
    for (int i = 0; i < 4; i++) cyc(0, 0, 0);
    cyc(0, 1, 0); cyc(0, 0, 1);
    cyc(0, 0, 0, "R7");
    cyc(0, 0, 0, "R9");
    // long run crossing 9999 -> 0000
    cyc(1, 0, 0); cyc(1, 0, 0);
    for (int i = 0; i < 10003; i++) cyc(0, 0, 0, "R5");
    cyc(0, 1, 0, "R5");
    cyc(1, 0, 0, "R6");
    // random traffic
    for (int i = 0; i < 40000; i++) begin
      bit g, h, k;
      g = ($urandom % 4) == 0;
      h = ($urandom % 25) == 0;
      k = ($urandom % 3) == 0;
      cyc(g, h, k);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule